// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers a set of peripheral interrupt events and decides when the processor core is interrupted and which vector address it jumps to. Each source keeps a sticky flag that its event sets. Each source also has an enable bit and a level bit that selects high or low. Software writes these registers through a small write port. The flags are cleared only by software, and the routine that services a source reads them through the flag output.

A mode bit chooses between two kinds of operation. With the mode bit off, the block has one level: every enabled request is gated by one global enable and goes to the high vector. With the mode bit on, two global enables gate the two levels on their own, and each level has its own fixed vector. A high request may interrupt a low service routine that is still running. The core acknowledges a request at an instruction boundary, and at that point the block clears the global enables that the entry masks. A return pulse puts those enables back, and a small nesting stack records which enables each entry cleared.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all flags, enables, level bits, the mode bit and both global enables are 0, and irq_req is 0.
- R2: A 1 on src_event[i] sets flag i on the next clock. The flag stays set until software writes a 1 to that bit with cfg_sel=2 (clear flags). If the event and the clear fall in the same cycle, the flag stays set.
- R3: irq_req is 1 only when some flag is set, its enable bit (cfg_sel=0) is set, and the global enable for its level is set. The control word is written with cfg_sel=3: bit0 is the high/global enable, bit1 is the low enable, and bit2 is the mode bit.
- R4: With the mode bit at 0, the level bits (cfg_sel=1) and the low enable have no effect. Every enabled flag is gated by bit0 alone and vectors to 0x0008.
- R5: With the mode bit at 1, sources whose level bit is 1 are gated by bit0 and vector to 0x0008. Sources whose level bit is 0 are gated by bit1 and vector to 0x0018.
- R6: A qualifying high request beats any low request. Within one level, the lowest source index wins and is reported on irq_src.
- R7: When irq_ack and irq_req are both 1, the entry clears global enables: a high entry in two-level mode clears both, a low entry clears only the low one, and any entry in one-level mode clears bit0.
- R8: Taking an interrupt does not clear any flag.
- R9: A pulse on irq_ret sets back exactly the global enables that the most recent unreturned entry cleared. Entries nest up to two deep.
- R10: irq_ack while irq_req is 0 has no effect, and irq_ret with no entry outstanding has no effect.
- R11: During a low service routine in two-level mode, a high request raises irq_req with vector 0x0008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | NSRC | Per-source event pulses |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 level, 2 clear flags, 3 control |
| cfg_data | input | NSRC | Write data |
| irq_ack | input | 1 | Core takes the interrupt at an instruction boundary |
| irq_ret | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address for the current request |
| irq_src | output | SRC_W | Index of the winning source |
| flag_out | output | NSRC | Current flag bits |
| gie_state | output | 2 | Global enables: bit0 high/global, bit1 low |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a source event and a software clear of the same flag. The bench drives both in one cycle and then checks at the flag output that the flag is still set. The second pair is a high and a low request competing for the core: they are provoked together from the stimulus table, and again during a low service routine to show preemption. In each case the vector, the source index and the global-enable state after the nested entry and return pulses are compared with values worked out from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_LVL  = 2'd1,
    SEL_FCLR = 2'd2,
    SEL_CTL  = 2'd3
  } cfg_sel_e;

  // index of the lowest set bit (0 when none)
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // enables removed by an entry: {lo, hi}
  function automatic logic [1:0] entry_mask(input logic two_lvl, input logic is_hi,
                                            input logic g_hi, input logic g_lo);
    if (!two_lvl) return {1'b0, g_hi};
    if (is_hi)    return {g_lo, g_hi};
    return {g_lo, 1'b0};
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_event,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [NSRC-1:0] cfg_data,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] lvl_q
);
  import irq_pkg::*;

  logic [NSRC-1:0] clr_bits;
  assign clr_bits = (cfg_we && cfg_sel == SEL_FCLR) ? cfg_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_bits) | src_event;
      if (cfg_we && cfg_sel == SEL_EN)  en_q  <= cfg_data;
      if (cfg_we && cfg_sel == SEL_LVL) lvl_q <= cfg_data;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int          NSRC   = 8,
  parameter int          VEC_W  = 16,
  parameter logic [VEC_W-1:0] HI_VEC = 16'h0008,
  parameter logic [VEC_W-1:0] LO_VEC = 16'h0018,
  localparam int         SRC_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  flag_q,
  input  logic [NSRC-1:0]  en_q,
  input  logic [NSRC-1:0]  lvl_q,
  input  logic             two_lvl,
  input  logic             g_hi,
  input  logic             g_lo,
  input  logic             room,
  output logic             req,
  output logic             sel_hi,
  output logic [VEC_W-1:0] vec,
  output logic [SRC_W-1:0] src
);
  import irq_pkg::*;

  logic [NSRC-1:0] live, hi_c, lo_c, win_c;
  logic            hi_ok, lo_ok;
  logic [31:0]     win_ext;

  always_comb begin
    live = flag_q & en_q;
    if (two_lvl) begin
      hi_c = live & lvl_q;
      lo_c = live & ~lvl_q;
      hi_ok = (|hi_c) && g_hi;
      lo_ok = (|lo_c) && g_lo;
    end else begin
      hi_c = live;
      lo_c = '0;
      hi_ok = (|hi_c) && g_hi;
      lo_ok = 1'b0;
    end
    sel_hi  = hi_ok;
    win_c   = hi_ok ? hi_c : lo_c;
    win_ext = '0;
    win_ext[NSRC-1:0] = win_c;
    req = (hi_ok || lo_ok) && room;
    vec = hi_ok ? HI_VEC : LO_VEC;
    src = SRC_W'(lowest_set(win_ext));
  end
endmodule

// File: rtl/irq_gate_stack.sv
module irq_gate_stack #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [NSRC-1:0] cfg_data,
  input  logic            take,
  input  logic            take_hi,
  input  logic            ret,
  output logic            g_hi,
  output logic            g_lo,
  output logic            two_lvl,
  output logic            room
);
  import irq_pkg::*;

  localparam int DEPTH = 2;
  localparam int DW    = $clog2(DEPTH + 1);

  logic [1:0]    saved_q [DEPTH];
  logic [DW-1:0] depth_q;
  logic [1:0]    gie_q, gie_base, gie_d, clr_m;
  logic          ctl_wr, pop_ok;

  assign ctl_wr = cfg_we && cfg_sel == SEL_CTL;
  assign pop_ok = ret && !take && depth_q != '0;
  assign clr_m  = entry_mask(two_lvl, take_hi, gie_q[0], gie_q[1]);
  assign room   = depth_q < DW'(DEPTH);

  always_comb begin
    gie_base = ctl_wr ? cfg_data[1:0] : gie_q;
    gie_d    = gie_base;
    if (take)        gie_d = gie_base & ~clr_m;
    else if (pop_ok) gie_d = gie_base | saved_q[depth_q - 1'b1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q   <= '0;
      two_lvl <= 1'b0;
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) saved_q[i] <= '0;
    end else begin
      gie_q <= gie_d;
      if (ctl_wr) two_lvl <= cfg_data[2];
      if (take) begin
        saved_q[depth_q] <= clr_m;
        depth_q <= depth_q + 1'b1;
      end else if (pop_ok) begin
        depth_q <= depth_q - 1'b1;
      end
    end
  end

  assign g_hi = gie_q[0];
  assign g_lo = gie_q[1];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int               NSRC   = 8,
  parameter int               VEC_W  = 16,
  parameter logic [VEC_W-1:0] HI_VEC = 16'h0008,
  parameter logic [VEC_W-1:0] LO_VEC = 16'h0018,
  localparam int              SRC_W  = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_event,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [NSRC-1:0]  cfg_data,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [SRC_W-1:0] irq_src,
  output logic [NSRC-1:0]  flag_out,
  output logic [1:0]       gie_state
);
  logic [NSRC-1:0] en_w, lvl_w;
  logic g_hi_w, g_lo_w, two_lvl_w, room_w, sel_hi_w;
  logic take_w;

  assign take_w = irq_ack && irq_req;

  irq_src_bank #(.NSRC(NSRC)) bank_i (
    .clk(clk), .rst_n(rst_n), .src_event(src_event),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .flag_q(flag_out), .en_q(en_w), .lvl_q(lvl_w)
  );

  irq_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)) arb_i (
    .flag_q(flag_out), .en_q(en_w), .lvl_q(lvl_w), .two_lvl(two_lvl_w),
    .g_hi(g_hi_w), .g_lo(g_lo_w), .room(room_w),
    .req(irq_req), .sel_hi(sel_hi_w), .vec(irq_vec), .src(irq_src)
  );

  irq_gate_stack #(.NSRC(NSRC)) gate_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .take(take_w), .take_hi(sel_hi_w), .ret(irq_ret),
    .g_hi(g_hi_w), .g_lo(g_lo_w), .two_lvl(two_lvl_w), .room(room_w)
  );

  assign gie_state = {g_lo_w, g_hi_w};
endmodule

module prio_irq_ctrl_chk #(
  parameter int               NSRC   = 8,
  parameter int               VEC_W  = 16,
  parameter logic [VEC_W-1:0] HI_VEC = 16'h0008,
  parameter logic [VEC_W-1:0] LO_VEC = 16'h0018,
  localparam int              SRC_W  = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [SRC_W-1:0] irq_src,
  input logic [NSRC-1:0]  flag_out,
  input logic [1:0]       gie_state,
  input logic             take_w
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie_state != 2'b00)); // R3
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == HI_VEC || irq_vec == LO_VEC)); // R5
  AST_WINNER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> flag_out[irq_src]); // R6
  AST_HI_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && irq_vec == HI_VEC && !cfg_we) |=> !gie_state[0]); // R7
  AST_LO_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && irq_vec == LO_VEC && !cfg_we) |=>
      (!gie_state[1] && gie_state[0] == $past(gie_state[0]))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_sel == 2'd2) |=> ((flag_out & $past(flag_out)) == $past(flag_out))); // R8
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .VEC_W(VEC_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_src(irq_src),
  .flag_out(flag_out), .gie_state(gie_state), .take_w(take_w)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NSRC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_event = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [NSRC-1:0] cfg_data = '0;
  logic irq_ack = 1'b0, irq_ret = 1'b0;
  logic irq_req;
  logic [15:0] irq_vec;
  logic [2:0] irq_src;
  logic [NSRC-1:0] flag_out;
  logic [1:0] gie_state;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_src(irq_src),
    .flag_out(flag_out), .gie_state(gie_state)
  );

  typedef struct packed {
    logic [7:0]  en;
    logic [7:0]  lvl;
    logic [2:0]  ctl;
    logic [7:0]  ev;
    logic        req;
    logic [15:0] vec;
    logic [2:0]  src;
  } row_t;

  // ctl: bit0 high/global enable, bit1 low enable, bit2 two-level mode
  localparam row_t TBL [10] = '{
    '{8'hFF, 8'h00, 3'b001, 8'h0C, 1'b1, 16'h0008, 3'd2}, // R4 R6
    '{8'hFF, 8'h0C, 3'b001, 8'h30, 1'b1, 16'h0008, 3'd4}, // R4 level ignored
    '{8'hF0, 8'h00, 3'b001, 8'h0F, 1'b0, 16'h0000, 3'd0}, // R3 disabled sources
    '{8'hFF, 8'h00, 3'b000, 8'hFF, 1'b0, 16'h0000, 3'd0}, // R3 global off
    '{8'hFF, 8'h80, 3'b111, 8'h81, 1'b1, 16'h0008, 3'd7}, // R6 high beats low
    '{8'hFF, 8'h80, 3'b110, 8'h81, 1'b1, 16'h0018, 3'd0}, // R5 high gated off
    '{8'hFF, 8'h00, 3'b101, 8'h06, 1'b0, 16'h0000, 3'd0}, // R5 low gated off
    '{8'hFF, 8'h00, 3'b111, 8'h06, 1'b1, 16'h0018, 3'd1}, // R5 R6 low lowest index
    '{8'hFF, 8'h02, 3'b110, 8'h02, 1'b0, 16'h0000, 3'd0}, // R5 high needs bit0
    '{8'hFF, 8'h00, 3'b010, 8'h01, 1'b0, 16'h0000, 3'd0}  // R4 low enable ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = '0;
  endtask

  task automatic pulse_ev(input logic [7:0] v);
    @(negedge clk); src_event = v;
    @(negedge clk); src_event = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 flags", flag_out, 0);
    chk("R1 gie", gie_state, 0);

    foreach (TBL[k]) begin
      wr(2'd2, 8'hFF);
      wr(2'd0, TBL[k].en);
      wr(2'd1, TBL[k].lvl);
      wr(2'd3, {5'd0, TBL[k].ctl});
      pulse_ev(TBL[k].ev);
      chk("R3/R4/R5 table req", irq_req, TBL[k].req);
      if (TBL[k].req) begin
        chk("R5 table vec", irq_vec, TBL[k].vec);
        chk("R6 table src", irq_src, TBL[k].src);
      end
    end

    // R2 sticky flags, clear and same-cycle event
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h00);
    pulse_ev(8'h05);
    chk("R2 flag set", flag_out, 8'h05);
    repeat (3) @(negedge clk);
    chk("R2 flag held", flag_out, 8'h05);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_data = 8'h05; src_event = 8'h01;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = '0; src_event = '0;
    chk("R2 event beats clear", flag_out, 8'h01);

    // one-level entry and return
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'h01);
    chk("R3 request up", irq_req, 1);
    do_ack();
    chk("R7 one-level entry", gie_state, 2'b00);
    chk("R8 flag kept", flag_out, 8'h01);
    chk("R7 request masked", irq_req, 0);
    do_ret();
    chk("R9 restore", gie_state, 2'b01);
    chk("R9 request again", irq_req, 1);

    // R10 ignored ack and ret
    wr(2'd3, 8'h02);
    chk("R4 low enable alone", irq_req, 0);
    do_ack();
    chk("R10 ack ignored", gie_state, 2'b10);
    do_ret();
    chk("R10 ret ignored", gie_state, 2'b10);

    // two-level nesting
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h80);
    wr(2'd3, 8'h07);
    pulse_ev(8'h01);
    chk("R5 low vec", irq_vec, 16'h0018);
    do_ack();
    chk("R7 low entry", gie_state, 2'b01);
    chk("R7 low masked", irq_req, 0);
    pulse_ev(8'h80);
    chk("R11 preempt req", irq_req, 1);
    chk("R11 preempt vec", irq_vec, 16'h0008);
    chk("R11 preempt src", irq_src, 3'd7);
    do_ack();
    chk("R7 high entry", gie_state, 2'b00);
    chk("R8 both flags", flag_out, 8'h81);
    do_ret();
    chk("R9 high return", gie_state, 2'b01);
    wr(2'd2, 8'h80);
    chk("R9 low still masked", irq_req, 0);
    do_ret();
    chk("R9 low return", gie_state, 2'b11);
    chk("R9 low req again", irq_vec, 16'h0018);
    do_ret();
    chk("R10 extra ret", gie_state, 2'b11);

    finish_run();
  end
endmodule